// File: doc/BRIEF.md
# Store-to-Load Forwarding Lookup

This block sits beside a load pipeline and answers one question per load: which bytes of the load can be taken from older stores that have not yet left the store queue, and what are those bytes? It keeps a ring of store entries. Each entry holds an address-known flag, a data-ready flag, a virtual address, a physical address, a 16-bit byte mask and 128 bits of data. A separate write port fills these entries. Allocation, draining to the cache and replay scheduling belong to other blocks.

A query carries a virtual address, a physical address, a byte mask and a predecoded mask of the entries older than the load. An earlier stage computes that mask from wrap-tagged queue pointers, so a wrapped ring needs no extra work here. The query also carries the load's ring position, which sets the age order. One cycle after the query the block returns a fast per-byte hit mask and a fast data-not-ready flag. One cycle after that it returns the final mask and bytes, together with three replay or flush conditions and the entry indices they refer to:
- an older matching store whose data is not ready;
- an older store whose address is not yet known;
- a disagreement between the virtual-address and physical-address matches.

Top module: `stlf_lookup`

## Requirements
- R1: After synchronous reset all response valids, masks and flags are 0 and every entry is marked address-unknown and data-not-ready.
- R2: One cycle after a query (q_valid=1), f_valid=1. f_mask bit b is 1 when the store chosen for byte b (see R4) exists and its data is ready.
- R3: Two cycles after a query, r_valid=1 and r_mask equals the fast mask. Byte b of the forwarded data appears at r_data[8b+7:8b] and comes from the chosen store's data byte b. Bytes with r_mask bit 0 are zero.
- R4: A store is a candidate for byte b when it is older, its address is known, its virtual address matches the query above bit 3, its mask bit b is 1 and q_mask bit b is 1. The chosen store is the youngest candidate: searching backward from entry q_ptr-1, modulo ENTRIES, the first candidate found wins. The choice is made per byte.
- R5: Entries whose q_older bit is 0 never supply bytes and never raise a flag.
- R6: A store whose 16-byte block (address bits above bit 3) differs from the query, or whose mask shares no byte with q_mask, is not a candidate.
- R7: If some chosen store's data is not ready, f_data_wait=1 and, one cycle later, r_data_wait=1 with r_data_wait_idx set to the youngest such chosen store. Bytes taken from that store are not forwarded.
- R8: If any older entry's address is unknown, r_addr_wait=1 and r_addr_wait_idx is the youngest such entry, in the same backward order.
- R9: r_match_bad=1 when, for some older address-known entry, the virtual-address match (block equal and mask overlap) and the physical-address match differ.
- R10: A byte with q_mask bit 0 is never forwarded.
- R11: In a cycle with no query one or two cycles before, f_valid and r_valid are 0 and the masks and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one store entry |
| wr_idx | input | IDX_W | Entry written |
| wr_addr_ok | input | 1 | Address known flag for the entry |
| wr_data_ok | input | 1 | Data ready flag for the entry |
| wr_vaddr | input | VA_W | Store virtual address |
| wr_paddr | input | PA_W | Store physical address |
| wr_mask | input | BYTES | Store byte mask |
| wr_data | input | 8*BYTES | Store data, byte b at bits 8b+7:8b |
| q_valid | input | 1 | Load query this cycle |
| q_vaddr | input | VA_W | Load virtual address |
| q_paddr | input | PA_W | Load physical address |
| q_mask | input | BYTES | Load byte mask |
| q_older | input | ENTRIES | One bit per entry older than the load |
| q_ptr | input | IDX_W | Load ring position; q_ptr-1 is the youngest possible older entry |
| f_valid | output | 1 | Fast response valid |
| f_mask | output | BYTES | Fast per-byte forward mask |
| f_data_wait | output | 1 | Fast data-not-ready flag |
| r_valid | output | 1 | Final response valid |
| r_mask | output | BYTES | Final per-byte forward mask |
| r_data | output | 8*BYTES | Forwarded bytes |
| r_data_wait | output | 1 | Matching older store has data not ready |
| r_data_wait_idx | output | IDX_W | Entry causing r_data_wait |
| r_addr_wait | output | 1 | Older store with unknown address |
| r_addr_wait_idx | output | IDX_W | Entry causing r_addr_wait |
| r_match_bad | output | 1 | Virtual and physical matches disagree |

## Verification
The hardest case to reach is per-byte priority across the ring wrap. Several overlapping partial stores have to cover the same bytes, with the youngest older store sitting at a low index and older ones at the top of the ring. The bench gets there by writing entries 6, 7 and 0 with nested masks, then querying with q_ptr=1 and an older mask of {6,7,0}. It then repeats the query with entry 0 removed from the older mask. Expected bytes come from a model of the pending stores that walks backward from the load position.

// File: rtl/stlf_pkg.sv
package stlf_pkg;
  // Ring position reached by stepping k entries back from ptr.
  function automatic int ring_back(int ptr, int k, int n);
    return (ptr + n - k) % n;
  endfunction
endpackage

// File: rtl/stlf_youngest.sv
module stlf_youngest #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic [ENTRIES-1:0] cand,
  input  logic [IDX_W-1:0]   ptr,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);
  // The scan runs from oldest to youngest, so the last hit written is the nearest to ptr.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = ENTRIES; k >= 1; k--) begin
      int pos;
      pos = stlf_pkg::ring_back(int'(ptr), k, ENTRIES);
      if (cand[pos]) begin
        hit = 1'b1;
        idx = pos[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/stlf_entry_store.sv
module stlf_entry_store #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 16,
  parameter int PA_W    = 20,
  parameter int BYTES   = 16,
  parameter int IDX_W   = 3,
  parameter int OFF_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic                     wr_addr_ok,
  input  logic                     wr_data_ok,
  input  logic [VA_W-1:0]          wr_vaddr,
  input  logic [PA_W-1:0]          wr_paddr,
  input  logic [BYTES-1:0]         wr_mask,
  input  logic [8*BYTES-1:0]       wr_data,
  input  logic [VA_W-1:0]          q_vaddr,
  input  logic [PA_W-1:0]          q_paddr,
  input  logic [BYTES-1:0]         q_mask,
  input  logic [ENTRIES-1:0]       q_older,
  input  logic [BYTES*IDX_W-1:0]   rd_sel,
  output logic [ENTRIES-1:0]       vmatch,
  output logic [ENTRIES-1:0]       pmatch,
  output logic [ENTRIES-1:0]       addr_ok,
  output logic [ENTRIES-1:0]       data_ok,
  output logic [ENTRIES*BYTES-1:0] st_mask,
  output logic [8*BYTES-1:0]       rd_bytes
);
  logic [ENTRIES-1:0] aok_q, dok_q;
  logic [VA_W-1:0]    va_q   [ENTRIES];
  logic [PA_W-1:0]    pa_q   [ENTRIES];
  logic [BYTES-1:0]   mask_q [ENTRIES];
  logic [8*BYTES-1:0] data_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      aok_q <= '0;
      dok_q <= '0;
    end else if (wr_en) begin
      aok_q[wr_idx] <= wr_addr_ok;
      dok_q[wr_idx] <= wr_data_ok;
    end
  end

  // Payload carries no reset so it can map onto plain storage.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      va_q[wr_idx]   <= wr_vaddr;
      pa_q[wr_idx]   <= wr_paddr;
      mask_q[wr_idx] <= wr_mask;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign addr_ok = aok_q;
  assign data_ok = dok_q;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic overlap;
    assign overlap   = |(mask_q[i] & q_mask);
    assign vmatch[i] = q_older[i] & aok_q[i] & overlap &
                       (va_q[i][VA_W-1:OFF_W] == q_vaddr[VA_W-1:OFF_W]);
    assign pmatch[i] = q_older[i] & aok_q[i] & overlap &
                       (pa_q[i][PA_W-1:OFF_W] == q_paddr[PA_W-1:OFF_W]);
    assign st_mask[i*BYTES +: BYTES] = mask_q[i];
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_rd
    assign rd_bytes[8*b +: 8] = data_q[rd_sel[b*IDX_W +: IDX_W]][8*b +: 8];
  end
endmodule

// File: rtl/stlf_lookup.sv
module stlf_lookup #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 16,
  parameter int PA_W    = 20,
  parameter int BYTES   = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int OFF_W  = $clog2(BYTES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_addr_ok,
  input  logic               wr_data_ok,
  input  logic [VA_W-1:0]    wr_vaddr,
  input  logic [PA_W-1:0]    wr_paddr,
  input  logic [BYTES-1:0]   wr_mask,
  input  logic [8*BYTES-1:0] wr_data,
  input  logic               q_valid,
  input  logic [VA_W-1:0]    q_vaddr,
  input  logic [PA_W-1:0]    q_paddr,
  input  logic [BYTES-1:0]   q_mask,
  input  logic [ENTRIES-1:0] q_older,
  input  logic [IDX_W-1:0]   q_ptr,
  output logic               f_valid,
  output logic [BYTES-1:0]   f_mask,
  output logic               f_data_wait,
  output logic               r_valid,
  output logic [BYTES-1:0]   r_mask,
  output logic [8*BYTES-1:0] r_data,
  output logic               r_data_wait,
  output logic [IDX_W-1:0]   r_data_wait_idx,
  output logic               r_addr_wait,
  output logic [IDX_W-1:0]   r_addr_wait_idx,
  output logic               r_match_bad
);
  logic [ENTRIES-1:0]       vmatch, pmatch, addr_ok, data_ok;
  logic [ENTRIES*BYTES-1:0] st_mask;
  logic [8*BYTES-1:0]       rd_bytes;
  logic [BYTES*IDX_W-1:0]   s1_sel;

  stlf_entry_store #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .BYTES(BYTES),
    .IDX_W(IDX_W), .OFF_W(OFF_W)
  ) store_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_addr_ok(wr_addr_ok), .wr_data_ok(wr_data_ok),
    .wr_vaddr(wr_vaddr), .wr_paddr(wr_paddr), .wr_mask(wr_mask), .wr_data(wr_data),
    .q_vaddr(q_vaddr), .q_paddr(q_paddr), .q_mask(q_mask), .q_older(q_older),
    .rd_sel(s1_sel), .vmatch(vmatch), .pmatch(pmatch), .addr_ok(addr_ok),
    .data_ok(data_ok), .st_mask(st_mask), .rd_bytes(rd_bytes)
  );

  // Stage 0: per-byte candidate vectors and youngest-older selection.
  logic [ENTRIES-1:0] cand [BYTES];
  logic [BYTES-1:0]   byte_hit;
  logic [IDX_W-1:0]   byte_sel [BYTES];

  always_comb begin
    for (int b = 0; b < BYTES; b++)
      for (int i = 0; i < ENTRIES; i++)
        cand[b][i] = vmatch[i] & st_mask[i*BYTES + b] & q_mask[b];
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_pick
    stlf_youngest #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) pick_i (
      .cand(cand[b]), .ptr(q_ptr), .hit(byte_hit[b]), .idx(byte_sel[b])
    );
  end

  logic [BYTES-1:0]       fwd;
  logic [ENTRIES-1:0]     chosen;
  logic [BYTES*IDX_W-1:0] sel_flat;
  always_comb begin
    fwd      = '0;
    chosen   = '0;
    sel_flat = '0;
    for (int b = 0; b < BYTES; b++) begin
      sel_flat[b*IDX_W +: IDX_W] = byte_sel[b];
      if (byte_hit[b]) begin
        chosen[byte_sel[b]] = 1'b1;
        fwd[b]              = data_ok[byte_sel[b]];
      end
    end
  end

  logic [ENTRIES-1:0] dw_vec, aw_vec;
  logic               dw_any, aw_any;
  logic [IDX_W-1:0]   dw_idx, aw_idx;
  assign dw_vec = chosen & ~data_ok;
  assign aw_vec = q_older & ~addr_ok;

  stlf_youngest #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) dw_pick_i (
    .cand(dw_vec), .ptr(q_ptr), .hit(dw_any), .idx(dw_idx)
  );
  stlf_youngest #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) aw_pick_i (
    .cand(aw_vec), .ptr(q_ptr), .hit(aw_any), .idx(aw_idx)
  );

  // Stage 1: fast response plus state carried to the data stage.
  logic             s1_aw, s1_mb;
  logic [IDX_W-1:0] s1_dwi, s1_awi;
  always_ff @(posedge clk) begin
    if (rst) begin
      f_valid     <= 1'b0;
      f_mask      <= '0;
      f_data_wait <= 1'b0;
      s1_sel      <= '0;
      s1_dwi      <= '0;
      s1_aw       <= 1'b0;
      s1_awi      <= '0;
      s1_mb       <= 1'b0;
    end else begin
      f_valid     <= q_valid;
      f_mask      <= q_valid ? fwd : '0;
      f_data_wait <= q_valid & dw_any;
      s1_sel      <= q_valid ? sel_flat : '0;
      s1_dwi      <= q_valid ? dw_idx : '0;
      s1_aw       <= q_valid & aw_any;
      s1_awi      <= q_valid ? aw_idx : '0;
      s1_mb       <= q_valid & (vmatch != pmatch);
    end
  end

  // Stage 2: byte read by the registered selections.
  logic [8*BYTES-1:0] data_nxt;
  always_comb begin
    for (int b = 0; b < BYTES; b++)
      data_nxt[8*b +: 8] = f_mask[b] ? rd_bytes[8*b +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_valid         <= 1'b0;
      r_mask          <= '0;
      r_data          <= '0;
      r_data_wait     <= 1'b0;
      r_data_wait_idx <= '0;
      r_addr_wait     <= 1'b0;
      r_addr_wait_idx <= '0;
      r_match_bad     <= 1'b0;
    end else begin
      r_valid         <= f_valid;
      r_mask          <= f_mask;
      r_data          <= data_nxt;
      r_data_wait     <= f_data_wait;
      r_data_wait_idx <= s1_dwi;
      r_addr_wait     <= s1_aw;
      r_addr_wait_idx <= s1_awi;
      r_match_bad     <= s1_mb;
    end
  end
endmodule

// File: rtl/stlf_lookup_chk.sv
module stlf_lookup_chk #(
  parameter int ENTRIES = 8,
  parameter int BYTES   = 16,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               q_valid,
  input logic [BYTES-1:0]   q_mask,
  input logic [ENTRIES-1:0] q_older,
  input logic               f_valid,
  input logic [BYTES-1:0]   f_mask,
  input logic               f_data_wait,
  input logic               r_valid,
  input logic [BYTES-1:0]   r_mask,
  input logic [8*BYTES-1:0] r_data,
  input logic               r_data_wait,
  input logic [IDX_W-1:0]   r_data_wait_idx,
  input logic               r_addr_wait,
  input logic [IDX_W-1:0]   r_addr_wait_idx,
  input logic               r_match_bad
);
  logic [BYTES-1:0]   qm_d1, qm_d2;
  logic [ENTRIES-1:0] old_d1, old_d2;
  always_ff @(posedge clk) begin
    if (rst) begin
      qm_d1 <= '0; qm_d2 <= '0; old_d1 <= '0; old_d2 <= '0;
    end else begin
      qm_d1  <= q_valid ? q_mask : '0;
      qm_d2  <= qm_d1;
      old_d1 <= q_valid ? q_older : '0;
      old_d2 <= old_d1;
    end
  end

  logic stray;
  always_comb begin
    stray = 1'b0;
    for (int b = 0; b < BYTES; b++)
      if (!r_mask[b] && r_data[8*b +: 8] != 8'h00) stray = 1'b1;
  end

  a_r3_final_follows_fast: assert property (@(posedge clk) disable iff (rst)
    f_valid |=> (r_valid && r_mask == $past(f_mask) && r_data_wait == $past(f_data_wait)));
  a_r3_zero_unforwarded: assert property (@(posedge clk) disable iff (rst) !stray);
  a_r10_mask_inside_query: assert property (@(posedge clk) disable iff (rst)
    r_valid |-> ((r_mask & ~qm_d2) == '0));
  a_r7_wait_idx_older: assert property (@(posedge clk) disable iff (rst)
    r_data_wait |-> old_d2[r_data_wait_idx]);
  a_r8_addr_idx_older: assert property (@(posedge clk) disable iff (rst)
    r_addr_wait |-> old_d2[r_addr_wait_idx]);
  a_r11_fast_quiet: assert property (@(posedge clk) disable iff (rst)
    !f_valid |-> (f_mask == '0 && !f_data_wait));
  a_r11_final_quiet: assert property (@(posedge clk) disable iff (rst)
    !r_valid |-> (r_mask == '0 && !r_match_bad && !r_addr_wait && !r_data_wait));
endmodule

bind stlf_lookup stlf_lookup_chk #(.ENTRIES(ENTRIES), .BYTES(BYTES), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst(rst), .q_valid(q_valid), .q_mask(q_mask), .q_older(q_older),
  .f_valid(f_valid), .f_mask(f_mask), .f_data_wait(f_data_wait),
  .r_valid(r_valid), .r_mask(r_mask), .r_data(r_data), .r_data_wait(r_data_wait),
  .r_data_wait_idx(r_data_wait_idx), .r_addr_wait(r_addr_wait),
  .r_addr_wait_idx(r_addr_wait_idx), .r_match_bad(r_match_bad)
);

// File: tb/stlf_lookup_tb_top.sv
module stlf_lookup_tb_top;
  localparam int N = 8, VA_W = 16, PA_W = 20, NB = 16, IW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst;
  logic            wr_en, wr_addr_ok, wr_data_ok;
  logic [IW-1:0]   wr_idx;
  logic [VA_W-1:0] wr_vaddr;
  logic [PA_W-1:0] wr_paddr;
  logic [NB-1:0]   wr_mask;
  logic [8*NB-1:0] wr_data;
  logic            q_valid;
  logic [VA_W-1:0] q_vaddr;
  logic [PA_W-1:0] q_paddr;
  logic [NB-1:0]   q_mask;
  logic [N-1:0]    q_older;
  logic [IW-1:0]   q_ptr;
  logic            f_valid, f_data_wait, r_valid, r_data_wait, r_addr_wait, r_match_bad;
  logic [NB-1:0]   f_mask, r_mask;
  logic [8*NB-1:0] r_data;
  logic [IW-1:0]   r_data_wait_idx, r_addr_wait_idx;

  stlf_lookup #(.ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W), .BYTES(NB)) dut_i (.*);

  // Model of the pending stores.
  logic            m_aok [N];
  logic            m_dok [N];
  logic [VA_W-1:0] m_va  [N];
  logic [PA_W-1:0] m_pa  [N];
  logic [NB-1:0]   m_mask[N];
  logic [8*NB-1:0] m_data[N];

  typedef struct packed {
    logic [NB-1:0]   fm;
    logic            dw;
    logic [IW-1:0]   dwi;
    logic [8*NB-1:0] rd;
    logic            aw;
    logic [IW-1:0]   awi;
    logic            mb;
  } exp_t;

  exp_t  fq[$], rq[$];
  string ft[$], rt[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic wr(int idx, bit aok, bit dok, int va, int pa, int mask, int seed);
    @(negedge clk);
    wr_en = 1; wr_idx = IW'(idx); wr_addr_ok = aok; wr_data_ok = dok;
    wr_vaddr = VA_W'(va); wr_paddr = PA_W'(pa); wr_mask = NB'(mask);
    for (int b = 0; b < NB; b++) wr_data[8*b +: 8] = 8'(seed + b);
    m_aok[idx] = aok; m_dok[idx] = dok; m_va[idx] = wr_vaddr; m_pa[idx] = wr_paddr;
    m_mask[idx] = wr_mask; m_data[idx] = wr_data;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic exp_t model(int va, int pa, int qm, int older, int ptr);
    exp_t e;
    bit [N-1:0] dwset;
    e = '0; dwset = '0;
    for (int b = 0; b < NB; b++) begin
      int ch = -1;
      for (int k = 1; k <= N; k++) begin
        int j = (ptr + N - k) % N;
        if (ch < 0 && older[j] && m_aok[j] && qm[b] && m_mask[j][b] &&
            m_va[j][VA_W-1:4] == VA_W'(va) >> 4) ch = j;
      end
      if (ch >= 0) begin
        if (m_dok[ch]) begin
          e.fm[b] = 1; e.rd[8*b +: 8] = m_data[ch][8*b +: 8];
        end else dwset[ch] = 1;
      end
    end
    for (int k = N; k >= 1; k--) begin
      int j = (ptr + N - k) % N;
      if (dwset[j]) begin e.dw = 1; e.dwi = IW'(j); end
      if (older[j] && !m_aok[j]) begin e.aw = 1; e.awi = IW'(j); end
    end
    for (int j = 0; j < N; j++) begin
      bit ov, vm, pm;
      ov = (m_mask[j] & NB'(qm)) != 0;
      vm = older[j] && m_aok[j] && ov && m_va[j][VA_W-1:4] == VA_W'(va) >> 4;
      pm = older[j] && m_aok[j] && ov && m_pa[j][PA_W-1:4] == PA_W'(pa) >> 4;
      if (vm != pm) e.mb = 1;
    end
    return e;
  endfunction

  // Driver: one query per call, held for one cycle.
  task automatic query(string tag, int va, int pa, int qm, int older, int ptr);
    exp_t e;
    @(negedge clk);
    e = model(va, pa, qm, older, ptr);
    fq.push_back(e); ft.push_back(tag); rq.push_back(e); rt.push_back(tag);
    q_valid = 1; q_vaddr = VA_W'(va); q_paddr = PA_W'(pa); q_mask = NB'(qm);
    q_older = N'(older); q_ptr = IW'(ptr);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    q_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares the outputs against the expected queues.
  always @(negedge clk) begin
    if (!rst && f_valid) begin
      exp_t e; string t;
      checks++;
      if (fq.size() == 0) begin
        errors++; $display("FAIL R2 unexpected fast response");
      end else begin
        e = fq.pop_front(); t = ft.pop_front();
        if (f_mask !== e.fm || f_data_wait !== e.dw) begin
          errors++;
          $display("FAIL %s fast: mask=%h wait=%b expected mask=%h wait=%b",
                   t, f_mask, f_data_wait, e.fm, e.dw);
        end
      end
    end
    if (!rst && r_valid) begin
      exp_t e; string t;
      checks++;
      if (rq.size() == 0) begin
        errors++; $display("FAIL R3 unexpected final response");
      end else begin
        e = rq.pop_front(); t = rt.pop_front();
        if (r_mask !== e.fm || r_data !== e.rd || r_data_wait !== e.dw ||
            (e.dw && r_data_wait_idx !== e.dwi) || r_addr_wait !== e.aw ||
            (e.aw && r_addr_wait_idx !== e.awi) || r_match_bad !== e.mb) begin
          errors++;
          $display("FAIL %s final: mask=%h data=%h dw=%b/%0d aw=%b/%0d mb=%b expected mask=%h data=%h dw=%b/%0d aw=%b/%0d mb=%b",
                   t, r_mask, r_data, r_data_wait, r_data_wait_idx, r_addr_wait,
                   r_addr_wait_idx, r_match_bad, e.fm, e.rd, e.dw, e.dwi, e.aw, e.awi, e.mb);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < N; j++) begin
      m_aok[j] = 0; m_dok[j] = 0; m_va[j] = '0; m_pa[j] = '0; m_mask[j] = '0; m_data[j] = '0;
    end
    rst = 1; wr_en = 0; wr_idx = '0; wr_addr_ok = 0; wr_data_ok = 0; wr_vaddr = '0;
    wr_paddr = '0; wr_mask = '0; wr_data = '0; q_valid = 0; q_vaddr = '0; q_paddr = '0;
    q_mask = '0; q_older = '0; q_ptr = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checks++;
    if (f_valid || r_valid || f_mask != 0 || r_mask != 0 || r_addr_wait || r_match_bad) begin
      errors++; $display("FAIL R1 reset state: fv=%b rv=%b fm=%h expected all 0", f_valid, r_valid, f_mask);
    end
    // R1/R8: after reset every entry is address-unknown.
    query("R1 all unknown", 'h100, 'h2100, 'hFFFF, 'hFF, 0); idle(1);
    // R2/R3: single store, partial overlap with the load.
    wr(0, 1, 1, 'h100, 'h2100, 'h000F, 'h10);
    query("R2 single store", 'h104, 'h2104, 'h00FF, 'h01, 1); idle(1);
    // R4: a younger store overrides bytes 1..2.
    wr(1, 1, 1, 'h108, 'h2108, 'h0006, 'h40);
    query("R4 overlap", 'h100, 'h2100, 'hFFFF, 'h03, 2); idle(1);
    // R4: ring wrap, youngest older is entry 0.
    wr(6, 1, 1, 'h100, 'h2100, 'hFF00, 'h60);
    wr(7, 1, 1, 'h100, 'h2100, 'h0F00, 'h70);
    wr(0, 1, 1, 'h100, 'h2100, 'h0300, 'h80);
    query("R4 wrap", 'h100, 'h2100, 'hFFFF, 'hC1, 1); idle(1);
    query("R5 older filter", 'h100, 'h2100, 'hFFFF, 'hC0, 0); idle(1);
    query("R6 other block", 'h110, 'h2110, 'hFFFF, 'hC1, 1); idle(1);
    query("R6 disjoint mask", 'h100, 'h2100, 'h00FF, 'hC0, 0); idle(1);
    query("R10 partial load", 'h100, 'h2100, 'h0F00, 'hC1, 1); idle(1);
    // R7: the youngest matching store has no data yet.
    wr(2, 1, 1, 'h200, 'h2200, 'h0FF0, 'hA0);
    wr(3, 1, 0, 'h200, 'h2200, 'h00F0, 'hB0);
    query("R7 data wait", 'h200, 'h2200, 'hFFFF, 'h0C, 4); idle(1);
    // R8: an older store with unknown address.
    wr(4, 0, 0, 'h200, 'h2200, 'hFFFF, 'hD0);
    query("R8 addr wait", 'h200, 'h2200, 'hFFFF, 'h1C, 5); idle(1);
    // R9: virtual match without a physical match.
    wr(5, 1, 1, 'h300, 'h2900, 'h000F, 'hC0);
    query("R9 match bad", 'h300, 'h2300, 'h000F, 'h20, 6); idle(1);
    query("R9 match agree", 'h300, 'h2900, 'h000F, 'h20, 6); idle(1);
    // Back-to-back queries.
    query("R4 back to back a", 'h100, 'h2100, 'hFFFF, 'hC1, 1);
    query("R2 back to back b", 'h300, 'h2900, 'hFFFF, 'h20, 6);
    idle(4);
    checks++;
    if (f_valid || r_valid || f_mask != 0 || r_mask != 0 || r_match_bad || r_addr_wait) begin
      errors++; $display("FAIL R11 idle: fv=%b rv=%b fm=%h rm=%h expected 0", f_valid, r_valid, f_mask, r_mask);
    end
    checks++;
    if (fq.size() != 0 || rq.size() != 0) begin
      errors++; $display("FAIL R3 missing responses: %0d/%0d expected 0/0", fq.size(), rq.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule